// File: doc/BRIEF.md
# Indexed Interrupt Mask and Priority Unit

This block sits between 64 level-sensitive interrupt request lines and a processor's interrupt entry logic. Each source carries a small priority level held in its own byte-wide control register. Among the requests that are both asserted and not masked, the block reports the highest level present and the smallest source number carrying that level. Both results come from registers and appear one clock after the inputs that produce them.

Software never writes the 64-bit mask as a word. It writes a source number to a "mask one" command register to block that source. It writes a source number to an "unmask one" command register to let that source through. A value with bit 6 set applies the command to every source at once, so 0xFF blocks everything. The mask can be read back one byte at a time through a selector port.

All register writes decode into one of five commands, and each command takes effect on the next clock edge: none, mask one, unmask one, mask all, unmask all. A second copy of the block, fed with source number minus 64, serves sources 64 to 127.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset every mask bit is 1, every level register is 0, and top_level and top_index are 0.
- R2: A write to address 0x40 with a value below 64 sets the mask bit of that source number and no other bit.
- R3: A write to address 0x41 with a value below 64 clears the mask bit of that source number and no other bit.
- R4: A write to address 0x40 with bit 6 of the value set (0x40, 0x7F, 0xFF and so on) sets all 64 mask bits.
- R5: A write to address 0x41 with bit 6 of the value set clears all 64 mask bits.
- R6: A write to 0x40 or 0x41 whose value has bit 7 set and bit 6 clear leaves the mask unchanged.
- R7: A write to address i (0 to 63) stores bits 2:0 of the value as the level of source i. Bits 7:3 are dropped.
- R8: A source whose level is 0, or whose mask bit is 1, never wins, even while its request is high.
- R9: top_level equals the largest level among sources that are requesting, unmasked and at a nonzero level. It is 0 when no such source exists.
- R10: top_index is the lowest source number at that largest level. It is 0 when top_level is 0.
- R11: top_level and top_index reflect the requests, mask and levels exactly one clock edge later.
- R12: rd_data presents mask bits [8*rd_sel+7 : 8*rd_sel] combinationally.
- R13: Writes to addresses 0x42 to 0xFF change neither the mask nor any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: 0-63 level registers, 0x40 mask one/all, 0x41 unmask one/all |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Mask byte selector |
| rd_data | output | 8 | Selected mask byte |
| irq_req | input | 64 | Level request per source |
| top_level | output | 3 | Highest active level, 0 when none |
| top_index | output | 6 | Lowest source number at that level |

## Verification
The mask commands are exercised for every source number. Each command is applied to a clear mask and then to a full mask, so a decode that touches the wrong bit, or more than one bit, shows up in the byte-wise readback. Out-of-range values and foreign addresses are written to check that they change nothing. The priority function is driven in four ways:
- one-hot requests against a spread of levels, to separate per-source level storage from the level-0 exclusion;
- pseudo-random request and mask patterns checked against an arithmetic model;
- an all-requests tie between two sources at the same level, to check the lowest-index rule;
- a request edge sampled before and after one clock, to pin down the single cycle of latency.

// File: rtl/imc_pkg.sv
package imc_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MASK_ONE,
        CMD_UNMASK_ONE,
        CMD_MASK_ALL,
        CMD_UNMASK_ALL
    } mask_cmd_e;
endpackage

// File: rtl/imc_wr_decode.sv
module imc_wr_decode
    import imc_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int LVL_W   = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ALL_BIT = 6,
    parameter int IDX_W   = $clog2(N_SRC)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mask_cmd_e         cmd,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic              lvl_we,
    output logic [IDX_W-1:0]  lvl_idx,
    output logic [LVL_W-1:0]  lvl_val
);
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(N_SRC);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(N_SRC + 1);

    logic is_set, is_clr, all_hit, one_hit;

    always_comb begin
        is_set  = wr_en && (wr_addr == SET_ADDR);
        is_clr  = wr_en && (wr_addr == CLR_ADDR);
        all_hit = wr_data[ALL_BIT];
        one_hit = !all_hit && (wr_data < DATA_W'(N_SRC));
        cmd     = CMD_NONE;
        unique case ({is_set, is_clr})
            2'b10: begin
                if (all_hit)      cmd = CMD_MASK_ALL;
                else if (one_hit) cmd = CMD_MASK_ONE;
            end
            2'b01: begin
                if (all_hit)      cmd = CMD_UNMASK_ALL;
                else if (one_hit) cmd = CMD_UNMASK_ONE;
            end
            default: cmd = CMD_NONE;
        endcase
        cmd_idx = wr_data[IDX_W-1:0];
        lvl_we  = wr_en && (wr_addr < ADDR_W'(N_SRC));
        lvl_idx = wr_addr[IDX_W-1:0];
        lvl_val = wr_data[LVL_W-1:0];
    end
endmodule

// File: rtl/imc_mask_reg.sv
module imc_mask_reg
    import imc_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mask_cmd_e        cmd,
    input  logic [IDX_W-1:0] cmd_idx,
    output logic [N_SRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            unique case (cmd)
                CMD_NONE:       mask_q <= mask_q;
                CMD_MASK_ONE:   mask_q[cmd_idx] <= 1'b1;
                CMD_UNMASK_ONE: mask_q[cmd_idx] <= 1'b0;
                CMD_MASK_ALL:   mask_q <= '1;
                CMD_UNMASK_ALL: mask_q <= '0;
                default:        mask_q <= mask_q;
            endcase
        end
    end
endmodule

// File: rtl/imc_level_bank.sv
module imc_level_bank #(
    parameter int N_SRC = 64,
    parameter int LVL_W = 3,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lvl_we,
    input  logic [IDX_W-1:0]       lvl_idx,
    input  logic [LVL_W-1:0]       lvl_val,
    output logic [N_SRC*LVL_W-1:0] lvl_flat
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [LVL_W-1:0] lvl_r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_r <= '0;
            else if (lvl_we && (lvl_idx == IDX_W'(g)))
                lvl_r <= lvl_val;
        end
        assign lvl_flat[g*LVL_W +: LVL_W] = lvl_r;
    end
endmodule

// File: rtl/imc_arbiter.sv
module imc_arbiter #(
    parameter int N_SRC = 64,
    parameter int LVL_W = 3,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC-1:0]       mask,
    input  logic [N_SRC*LVL_W-1:0] lvl_flat,
    output logic [LVL_W-1:0]       top_level,
    output logic [IDX_W-1:0]       top_index
);
    logic [LVL_W-1:0] best_lvl;
    logic [IDX_W-1:0] best_idx;

    // strict compare keeps the lowest index on a tie; level 0 never beats 0
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (req[s] && !mask[s] && (lvl_flat[s*LVL_W +: LVL_W] > best_lvl)) begin
                best_lvl = lvl_flat[s*LVL_W +: LVL_W];
                best_idx = IDX_W'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_level <= '0;
            top_index <= '0;
        end else begin
            top_level <= best_lvl;
            top_index <= best_idx;
        end
    end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
    import imc_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int LVL_W   = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ALL_BIT = 6,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int SEL_W  = $clog2(N_SRC / DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SRC-1:0]  irq_req,
    output logic [LVL_W-1:0]  top_level,
    output logic [IDX_W-1:0]  top_index
);
    mask_cmd_e              cmd;
    logic [IDX_W-1:0]       cmd_idx;
    logic                   lvl_we;
    logic [IDX_W-1:0]       lvl_idx;
    logic [LVL_W-1:0]       lvl_val;
    logic [N_SRC-1:0]       mask_q;
    logic [N_SRC*LVL_W-1:0] lvl_flat;

    imc_wr_decode #(
        .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .ALL_BIT(ALL_BIT), .IDX_W(IDX_W)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd(cmd), .cmd_idx(cmd_idx),
        .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_val(lvl_val)
    );

    imc_mask_reg #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_idx(cmd_idx), .mask_q(mask_q)
    );

    imc_level_bank #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .lvl_idx(lvl_idx),
        .lvl_val(lvl_val), .lvl_flat(lvl_flat)
    );

    imc_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .mask(mask_q),
        .lvl_flat(lvl_flat), .top_level(top_level), .top_index(top_index)
    );

    assign rd_data = mask_q[int'(rd_sel) * DATA_W +: DATA_W];
endmodule

// File: rtl/imc_checker.sv
module imc_checker #(
    parameter int N_SRC   = 64,
    parameter int LVL_W   = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ALL_BIT = 6,
    parameter int IDX_W   = $clog2(N_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [N_SRC-1:0]  irq_req,
    input logic [N_SRC-1:0]  mask,
    input logic [LVL_W-1:0]  top_level,
    input logic [IDX_W-1:0]  top_index
);
    logic to_set, to_clr, val_all, val_one, val_bad;
    assign to_set  = wr_en && (wr_addr == ADDR_W'(N_SRC));
    assign to_clr  = wr_en && (wr_addr == ADDR_W'(N_SRC + 1));
    assign val_all = wr_data[ALL_BIT];
    assign val_one = !val_all && (wr_data < DATA_W'(N_SRC));
    assign val_bad = !val_all && !val_one;

    p_mask_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (to_set && val_one) |=> mask[$past(wr_data[IDX_W-1:0])]);

    p_unmask_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clr && val_one) |=> !mask[$past(wr_data[IDX_W-1:0])]);

    p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (to_set && val_all) |=> (&mask));

    p_unmask_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clr && val_all) |=> (mask == '0));

    p_bad_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((to_set || to_clr) && val_bad) |=> $stable(mask));

    p_foreign_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > ADDR_W'(N_SRC + 1))) |=> $stable(mask));

    p_winner_came_from_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (top_level != '0) |-> $past(|(irq_req & ~mask)));

    p_idle_index_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_level == '0) |-> (top_index == '0));
endmodule

bind irq_mask_unit imc_checker #(
    .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ALL_BIT(ALL_BIT), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_req(irq_req), .mask(mask_q),
    .top_level(top_level), .top_index(top_index)
);

// File: tb/sim_irq_mask_unit.sv
module sim_irq_mask_unit;
    localparam logic [7:0] A_SET = 8'h40;
    localparam logic [7:0] A_CLR = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_addr, wr_data;
    logic [2:0]  rd_sel;
    logic [7:0]  rd_data;
    logic [63:0] irq_req;
    logic [2:0]  top_level;
    logic [5:0]  top_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_mask;
    logic [2:0]  m_lvl [64];

    always #5 clk = ~clk;

    irq_mask_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_req(irq_req), .top_level(top_level), .top_index(top_index)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_mask(output logic [63:0] v);
        for (int b = 0; b < 8; b++) begin
            rd_sel = 3'(b);
            #1;
            v[b*8 +: 8] = rd_data;
        end
    endtask

    task automatic chk_mask(input string r);
        logic [63:0] v;
        read_mask(v);
        chk(r, v, m_mask);
    endtask

    function automatic logic [8:0] model(input logic [63:0] req);
        logic [2:0] bl;
        logic [5:0] bi;
        bl = 3'd0; bi = 6'd0;
        for (int s = 0; s < 64; s++)
            if (req[s] && !m_mask[s] && m_lvl[s] > bl) begin
                bl = m_lvl[s]; bi = 6'(s);
            end
        return {bl, bi};
    endfunction

    task automatic chk_out(input string r);
        logic [8:0] e;
        @(negedge clk);
        e = model(irq_req);
        chk({r, " level"}, 64'(top_level), 64'(e[8:6]));
        chk({r, " index"}, 64'(top_index), 64'(e[5:0]));
    endtask

    task automatic set_lvl(input int i, input logic [2:0] v, input logic [4:0] junk);
        wr(8'(i), {junk, v});
        m_lvl[i] = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        logic [63:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_sel = '0; irq_req = '0;
        m_mask = '1;
        for (int i = 0; i < 64; i++) m_lvl[i] = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_mask("R1 mask after reset");
        chk("R1 top_level", 64'(top_level), 64'd0);
        chk("R1 top_index", 64'(top_index), 64'd0);
        irq_req = '1;
        chk_out("R1 all requests while masked");
        irq_req = '0;

        // R5 unmask all with two values carrying bit 6
        wr(A_CLR, 8'h40); m_mask = '0; chk_mask("R5 unmask all 0x40");
        wr(A_SET, 8'h05); m_mask[5] = 1'b1;
        wr(A_CLR, 8'hFF); m_mask = '0; chk_mask("R5 unmask all 0xFF");

        // R2 / R3 sweep from a clear mask
        for (int i = 0; i < 64; i++) begin
            wr(A_SET, 8'(i)); m_mask[i] = 1'b1; chk_mask("R2 mask one from clear");
            wr(A_CLR, 8'(i)); m_mask[i] = 1'b0; chk_mask("R3 unmask one to clear");
        end

        // R4 mask all, then sweep from a full mask
        wr(A_SET, 8'h40); m_mask = '1; chk_mask("R4 mask all 0x40");
        for (int i = 0; i < 64; i++) begin
            wr(A_CLR, 8'(i)); m_mask[i] = 1'b0; chk_mask("R3 unmask one from full");
            wr(A_SET, 8'(i)); m_mask[i] = 1'b1; chk_mask("R2 mask one back to full");
        end
        wr(A_CLR, 8'h7F); m_mask = '0; chk_mask("R5 unmask all 0x7F");
        wr(A_SET, 8'hFF); m_mask = '1; chk_mask("R4 mask all 0xFF");

        // R6 out-of-range values ignored
        wr(A_CLR, 8'h80); chk_mask("R6 unmask 0x80 ignored");
        wr(A_CLR, 8'hBF); chk_mask("R6 unmask 0xBF ignored");
        wr(A_CLR, 8'h40); m_mask = '0;
        wr(A_SET, 8'h80); chk_mask("R6 mask 0x80 ignored");
        wr(A_SET, 8'hA5); chk_mask("R6 mask 0xA5 ignored");

        // R12 byte readback of a sparse pattern
        for (int i = 0; i < 64; i += 7) begin
            wr(A_SET, 8'(i)); m_mask[i] = 1'b1;
        end
        for (int b = 0; b < 8; b++) begin
            rd_sel = 3'(b);
            #1;
            chk("R12 mask byte", 64'(rd_data), 64'(m_mask[b*8 +: 8]));
        end
        wr(A_CLR, 8'h40); m_mask = '0;

        // R7 / R8 levels with junk upper bits, one-hot requests
        for (int i = 0; i < 64; i++)
            set_lvl(i, 3'((i * 5 + 3) % 8), 5'(i) ^ 5'h15);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            irq_req = 64'd1 << i;
            chk_out("R7 one-hot level");
        end
        for (int i = 1; i < 64; i += 9) begin
            wr(A_SET, 8'(i)); m_mask[i] = 1'b1;
            irq_req = 64'd1 << i;
            chk_out("R8 masked single source");
        end
        wr(A_CLR, 8'h40); m_mask = '0;

        // R9 / R10 pseudo-random requests and masks
        x = 64'h9E3779B97F4A7C15;
        for (int k = 0; k < 40; k++) begin
            x ^= x << 13; x ^= x >> 7; x ^= x << 17;
            if (k % 3 == 0) begin
                wr(A_SET, {2'b00, x[5:0]}); m_mask[x[5:0]] = 1'b1;
            end
            if (k % 5 == 0) begin
                wr(A_CLR, {2'b00, x[11:6]}); m_mask[x[11:6]] = 1'b0;
            end
            irq_req = x;
            chk_out("R9 random pattern");
        end

        // R10 tie resolution, R8 level zero exclusion
        wr(A_CLR, 8'h40); m_mask = '0;
        for (int i = 0; i < 64; i++) set_lvl(i, 3'd2, 5'h1F);
        set_lvl(40, 3'd6, 5'h00);
        set_lvl(17, 3'd6, 5'h0A);
        irq_req = '1;
        chk_out("R10 tie all requests");
        chk("R10 tie lowest index", 64'(top_index), 64'd17);
        wr(A_SET, 8'd17); m_mask[17] = 1'b1;
        chk_out("R10 tie after masking 17");
        chk("R10 winner moves to 40", 64'(top_index), 64'd40);
        set_lvl(40, 3'd0, 5'h1F);
        chk_out("R8 level zero source");
        chk("R8 fallback level 2", 64'(top_level), 64'd2);

        // R13 foreign addresses ignored
        wr(8'h42, 8'h40);
        wr(8'hC5, 8'h07);
        wr(8'h80, 8'h07);
        chk_mask("R13 mask unchanged");
        chk_out("R13 outputs unchanged");

        // R11 one cycle latency
        for (int i = 0; i < 64; i++) set_lvl(i, 3'd0, 5'h00);
        set_lvl(33, 3'd5, 5'h00);
        irq_req = '0;
        chk_out("R11 idle");
        irq_req = 64'd1 << 33;
        #1;
        chk("R11 before edge", 64'(top_level), 64'd0);
        @(posedge clk);
        #1;
        chk("R11 after one edge level", 64'(top_level), 64'd5);
        chk("R11 after one edge index", 64'(top_index), 64'd33);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule